// File: doc/BRIEF.md
# Single-Cycle 32-bit Register Machine Core

This block is a small processor core that completes one instruction per clock. Each cycle it presents the program counter on an instruction port and takes back a 32-bit word. It splits that word into fixed fields and reads two source registers from a 32-entry register file. It then computes an arithmetic, logic, shift or compare result, or a memory address, and writes at most one register at the next rising edge. Data memory sits outside the block behind a byte-addressed word port. Loads read that port combinationally in the same cycle, and stores assert a write strobe for one cycle.

Three instruction shapes exist. The register form names two sources, a destination, a shift count and a function code. The immediate form names one source, one target and a 16-bit constant. The jump form carries a 26-bit target. No jump is executed here, because next-PC selection lives in its own block, and that block only advances by one word. A full 32-bit constant is built in two steps: an upper-immediate load sets the top half, and an OR-immediate then fills the bottom half.

Top module: `trc_core`

## Requirements
- R1: Instruction fields sit at fixed positions: opcode [31:26], first source [25:21], second source/target [20:16], destination [15:11], shift count [10:6], function [5:0], immediate [15:0]. Opcode 0 selects the register form, and function 32 there is add. The word 0x00AF8020 therefore writes reg5+reg15 into reg16.
- R2: Register 0 always reads as zero. A write whose destination is register 0 leaves it zero.
- R3: Add (function 32) and subtract (function 34) produce the 32-bit wrap-around sum and difference of the two sources.
- R4: Function 36 writes the bitwise AND of the sources, 37 writes the OR, and 39 writes the complement of their OR.
- R5: Function 42 and opcode 10 write 1 when the first operand is less than the second as signed two's complement values, and 0 otherwise.
- R6: Function 0 shifts the second source left, and function 2 shifts it right with zero fill, by the 5-bit shift count (0 to 31).
- R7: Opcode 8 (add immediate) and opcode 10 sign-extend the immediate. Opcode 12 (AND immediate) and opcode 13 (OR immediate) zero-extend it.
- R8: Opcode 15 writes the immediate into bits [31:16] and clears bits [15:0].
- R9: Opcode 35 loads and opcode 43 stores one word at address first-source plus sign-extended immediate. The write strobe rises only for opcode 43, and it carries the target register as data.
- R10: A synchronous active-high reset sets the program counter to 0. After reset the counter advances by 4 on every clock, so fetch addresses keep their two low bits at zero.
- R11: Register-form instructions write the destination field [15:11]. Immediate-form instructions and loads write the target field [20:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |

## Verification
The assertions assume that the instruction port returns a defined word in the same cycle as the address, and that the bench holds reset high from time zero. The step check of the program counter depends on that initial reset. The bench keeps within these limits by driving the instruction and data ports from combinational array reads. Every program builds its operands with upper-immediate and OR-immediate before using them, so no register is read before it is written. All register results are brought out through stores, and the bench compares the stored words, not internal state.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int NREG = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_SLTI = 6'd10;
  localparam logic [5:0] OP_ANDI = 6'd12;
  localparam logic [5:0] OP_ORI  = 6'd13;
  localparam logic [5:0] OP_LUI  = 6'd15;
  localparam logic [5:0] OP_LW   = 6'd35;
  localparam logic [5:0] OP_SW   = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLT, ALU_SLL, ALU_SRL, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {IMM_SEXT, IMM_ZEXT, IMM_UPPER} imm_kind_e;

  typedef struct packed {
    logic      rf_we;
    logic      dst_rd;
    logic      use_imm;
    logic      mem_rd;
    logic      mem_we;
    imm_kind_e imm_kind;
    alu_op_e   alu_op;
  } ctrl_t;
endpackage

// File: rtl/trc_decode.sv
module trc_decode
  import trc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]      instr,
  output ctrl_t            ctrl,
  output logic [RIDX-1:0]  rs_idx,
  output logic [RIDX-1:0]  rt_idx,
  output logic [RIDX-1:0]  wr_idx,
  output logic [4:0]       shamt,
  output logic [XLEN-1:0]  imm_ext
);
  localparam int HI = XLEN - 16;

  logic [5:0]  opc;
  logic [5:0]  fn;
  logic [15:0] imm16;

  assign opc    = instr[31:26];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign shamt  = instr[10:6];
  assign fn     = instr[5:0];
  assign imm16  = instr[15:0];

  always_comb begin
    ctrl.rf_we    = 1'b0;
    ctrl.dst_rd   = 1'b0;
    ctrl.use_imm  = 1'b0;
    ctrl.mem_rd   = 1'b0;
    ctrl.mem_we   = 1'b0;
    ctrl.imm_kind = IMM_SEXT;
    ctrl.alu_op   = ALU_ADD;
    case (opc)
      OP_REG: begin
        ctrl.rf_we  = 1'b1;
        ctrl.dst_rd = 1'b1;
        case (fn)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_NOR:  ctrl.alu_op = ALU_NOR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          FN_SLL:  ctrl.alu_op = ALU_SLL;
          FN_SRL:  ctrl.alu_op = ALU_SRL;
          default: ctrl.rf_we  = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_ADD;
      end
      OP_SLTI: begin
        ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT;
      end
      OP_ANDI: begin
        ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_AND;
        ctrl.imm_kind = IMM_ZEXT;
      end
      OP_ORI: begin
        ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_OR;
        ctrl.imm_kind = IMM_ZEXT;
      end
      OP_LUI: begin
        ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_PASSB;
        ctrl.imm_kind = IMM_UPPER;
      end
      OP_LW: begin
        ctrl.rf_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1;
      end
      OP_SW: begin
        ctrl.mem_we = 1'b1; ctrl.use_imm = 1'b1;
      end
      default: ;
    endcase
  end

  // R11: register form targets [15:11], everything else [20:16]
  assign wr_idx = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  always_comb begin
    case (ctrl.imm_kind)
      IMM_ZEXT:  imm_ext = {{HI{1'b0}}, imm16};
      IMM_UPPER: imm_ext = {imm16, {HI{1'b0}}};
      default:   imm_ext = {{HI{imm16[15]}}, imm16};
    endcase
  end
endmodule

// File: rtl/trc_regfile.sv
module trc_regfile
  import trc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = NREG
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [XLEN-1:0]          wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr_a,
  output logic [XLEN-1:0]          rdata_a,
  input  logic [$clog2(DEPTH)-1:0] raddr_b,
  output logic [XLEN-1:0]          rdata_b
);
  localparam int AW = $clog2(DEPTH);

  logic [XLEN-1:0] store [DEPTH];

  // write port only, no reset: maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) store[waddr] <= wdata;
  end

  // R2: entry 0 is never read from storage
  assign rdata_a = (raddr_a == AW'(0)) ? '0 : store[raddr_a];
  assign rdata_b = (raddr_b == AW'(0)) ? '0 : store[raddr_b];
endmodule

// File: rtl/trc_alu.sv
module trc_alu
  import trc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [4:0]      shamt,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_NOR:   y = ~(a | b);
      ALU_SLT:   y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL:   y = b << shamt;
      ALU_SRL:   y = b >> shamt;
      default:   y = b;
    endcase
  end
endmodule

// File: rtl/trc_pc.sv
module trc_pc #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + STEP;
  end

  assign pc = pc_q;

  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc_q == $past(pc_q) + STEP);
  p_pc_align_r10: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);
endmodule

// File: rtl/trc_core.sv
module trc_core
  import trc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  ctrl_t           ctrl;
  logic [RIDX-1:0] rs_idx, rt_idx, wr_idx;
  logic [4:0]      shamt;
  logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, wb_data;
  logic            rf_we;

  trc_pc #(.XLEN(XLEN)) u_pc (
    .clk(clk), .rst(rst), .pc(imem_addr)
  );

  trc_decode #(.XLEN(XLEN)) u_dec (
    .instr(imem_rdata), .ctrl(ctrl), .rs_idx(rs_idx), .rt_idx(rt_idx),
    .wr_idx(wr_idx), .shamt(shamt), .imm_ext(imm_ext)
  );

  assign rf_we   = ctrl.rf_we & ~rst;
  assign wb_data = ctrl.mem_rd ? dmem_rdata : alu_y;

  trc_regfile #(.XLEN(XLEN), .DEPTH(NREG)) u_rf (
    .clk(clk), .we(rf_we), .waddr(wr_idx), .wdata(wb_data),
    .raddr_a(rs_idx), .rdata_a(rs_val),
    .raddr_b(rt_idx), .rdata_b(rt_val)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

  trc_alu #(.XLEN(XLEN)) u_alu (
    .op(ctrl.alu_op), .a(rs_val), .b(alu_b), .shamt(shamt), .y(alu_y)
  );

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we & ~rst;

  p_store_nowb_r9: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we);
  p_zero_src_r2: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == '0) |-> (rs_val == '0));
  p_slt_bool_r5: assert property (@(posedge clk) disable iff (rst)
    (rf_we && ctrl.alu_op == ALU_SLT) |-> (wb_data[XLEN-1:1] == '0));
  p_lui_low_r8: assert property (@(posedge clk) disable iff (rst)
    (rf_we && imem_rdata[31:26] == OP_LUI) |-> (wb_data[15:0] == 16'h0));
  p_dest_field_r11: assert property (@(posedge clk) disable iff (rst)
    (rf_we && imem_rdata[31:26] == OP_REG) |-> (wr_idx == imem_rdata[15:11]));
endmodule

// File: tb/trc_core_tb.sv
module trc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] prog [64];
  logic [31:0] dmem [64];
  int          n_vec = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trc_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = prog[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: actual %0d cycles, expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] rt_w(input int rs, input int rt, input int rd,
                                       input int sh, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] it_w(input logic [5:0] op, input int rs,
                                       input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] expect_w(input int k, input logic [31:0] a,
                                           input logic [31:0] b);
    case (k)
      0:  return a + b;
      1:  return a - b;
      2:  return a & b;
      3:  return a | b;
      4:  return ~(a | b);
      5:  return {31'd0, $signed(a) < $signed(b)};
      6:  return a + sx(b[15:0]);
      7:  return {31'd0, $signed(a) < $signed(sx(b[15:0]))};
      8:  return a & {16'd0, b[15:0]};
      9:  return a | {16'd0, b[15:0]};
      10: return a << b[4:0];
      11: return a >> b[4:0];
      12: return {b[15:0], 16'd0};
      13: return 32'd0;
      14: return a - b;
      default: return a + b;
    endcase
  endfunction

  function automatic string req_of(input int k);
    case (k)
      0, 1: return "R3";
      2, 3, 4: return "R4";
      5, 7: return "R5";
      6, 8, 9: return "R7";
      10, 11: return "R6";
      12: return "R8";
      13: return "R2";
      14: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec = n_vec + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic build(input logic [31:0] a, input logic [31:0] b);
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = it_w(6'd15, 0, 1, a[31:16]);
    prog[1]  = it_w(6'd13, 1, 1, a[15:0]);
    prog[2]  = it_w(6'd15, 0, 2, b[31:16]);
    prog[3]  = it_w(6'd13, 2, 2, b[15:0]);
    prog[4]  = rt_w(1, 2, 3, 0, 6'd32);
    prog[6]  = rt_w(1, 2, 3, 0, 6'd34);
    prog[8]  = rt_w(1, 2, 3, 0, 6'd36);
    prog[10] = rt_w(1, 2, 3, 0, 6'd37);
    prog[12] = rt_w(1, 2, 3, 0, 6'd39);
    prog[14] = rt_w(1, 2, 3, 0, 6'd42);
    prog[16] = it_w(6'd8,  1, 3, b[15:0]);
    prog[18] = it_w(6'd10, 1, 3, b[15:0]);
    prog[20] = it_w(6'd12, 1, 3, b[15:0]);
    prog[22] = it_w(6'd13, 1, 3, b[15:0]);
    prog[24] = rt_w(0, 1, 3, int'(b[4:0]), 6'd0);
    prog[26] = rt_w(0, 1, 3, int'(b[4:0]), 6'd2);
    prog[28] = it_w(6'd15, 0, 3, b[15:0]);
    for (int k = 0; k < 13; k++)
      prog[5 + 2*k] = it_w(6'd43, 0, 3, 16'(4*k));
    // R2: write to register 0 then store it
    prog[30] = it_w(6'd8, 1, 0, b[15:0]);
    prog[31] = it_w(6'd43, 0, 0, 16'd52);
    // R9: load with negative offset from base 8 -> byte address 4
    prog[32] = it_w(6'd8, 0, 5, 16'd8);
    prog[33] = it_w(6'd35, 5, 4, 16'hFFFC);
    prog[34] = it_w(6'd43, 0, 4, 16'd56);
    // R1: fixed word 0x00AF8020 with r5=a, r15=b
    prog[35] = rt_w(1, 0, 5, 0, 6'd32);
    prog[36] = rt_w(2, 0, 15, 0, 6'd37);
    prog[37] = 32'h00AF8020;
    prog[38] = it_w(6'd43, 0, 16, 16'd60);
  endtask

  task automatic run_pair(input logic [31:0] a, input logic [31:0] b, input bit first);
    build(a, b);
    for (int i = 0; i < 64; i++) dmem[i] = 32'hDEADBEEF;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (first) begin
      check("R10 reset pc", imem_addr, 32'h0);
      check("R9 no store in reset", {31'd0, dmem_we}, 32'd0);
    end
    rst = 1'b0;
    if (first) begin
      @(negedge clk);
      check("R10 first fetch", imem_addr, 32'd4);
      repeat (4) @(negedge clk);
      check("R10 step by four", imem_addr, 32'd20);
      repeat (NPROG - 5) @(negedge clk);
    end else begin
      repeat (NPROG) @(negedge clk);
    end
    for (int k = 0; k < 16; k++)
      check(req_of(k), dmem[k], expect_w(k, a, b));
    check("R9 untouched word", dmem[16], 32'hDEADBEEF);
  endtask

  logic [31:0] vals [8];

  initial begin
    vals[0] = 32'h00000000; vals[1] = 32'h00000001;
    vals[2] = 32'hFFFFFFFF; vals[3] = 32'h80000000;
    vals[4] = 32'h7FFFFFFF; vals[5] = 32'h12348765;
    vals[6] = 32'hFFFF8000; vals[7] = 32'h0000001F;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run_pair(vals[i], vals[j], (i == 0) && (j == 0));
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule